// File: doc/BRIEF.md
# Reset-Sampled Debug Entry Controller

This block decides, at the moment a soft reset is released, how a processor's debug port behaves for the rest of that reset epoch. It watches two strap pins, a debug clock pin and a serial data-in pin, relative to the rising edge of an active-low soft reset. From that edge it derives three facts. Debug mode is either allowed or not. The core either enters debug at once or runs normally. The port is clocked either by the external debug clock or by the system clock. Each fact comes from a pin level taken at a fixed system-clock offset from the release.

Once the sampling window has closed, interrupt-cause events are gathered in sticky pending bits that software clears by writing. A pending cause whose mask bit is set triggers debug entry, provided debug mode is allowed. While the core is held in debug the block drives a freeze output. A return-from-interrupt pulse ends debug, and the core then carries on from where it stopped. Asserting the soft reset again clears every decision, so the next release samples the straps afresh.

Top module: `dbg_entry_ctl`

## Requirements
- R1: After the chip reset `rst_n` is released, and while `soft_rst_n` is low, `freeze`, `dbg_enabled` and `mode_valid` are 0 and `cause_pend` is all zeros.
- R2: Call E0 the first clock edge at which `soft_rst_n` is sampled high after being low. `dbg_enabled` becomes 1 after E0 exactly when `dbg_clk_pin` was sampled high at the edge PRE_CYC (3) edges before E0. Pin levels at the later edges before E0 do not matter.
- R3: If `dbg_enabled` is 1 and `dbg_clk_pin` is still high at edge E0+IMM_CYC (E7), `freeze` rises after that edge. Before it, `freeze` stays 0.
- R4: If `dbg_clk_pin` is low at E7, no immediate entry happens and `freeze` stays 0.
- R5: `dbg_din_pin` is sampled at edge E0+DIN_CYC (E8). After that edge `mode_valid` is 1 and `self_clocked` equals the sampled level: 0 means the port is clocked by the external debug clock, 1 means it is clocked by the system clock. Both then stay unchanged until the next soft reset.
- R6: `cause_pend` bits are sticky. A 1 in `cause_set` sets the bit on the next edge, and a 1 in `cause_clr` clears it. When the same bit is both set and cleared in one cycle, the set wins.
- R7: When `dbg_enabled` and `mode_valid` are both 1 and `cause_pend & cause_mask` is nonzero, `freeze` rises on the next edge. A pending cause whose mask bit is 0 causes no entry.
- R8: When `dbg_enabled` is 0, neither pending causes nor the strap pins ever raise `freeze`.
- R9: A 1 on `rfi` while `freeze` is 1 clears `freeze` on the next edge, even if an entry condition holds in that cycle. A 1 on `rfi` while `freeze` is 0 has no effect.
- R10: `soft_rst_n` low clears `freeze`, `dbg_enabled`, `mode_valid`, `self_clocked` and `cause_pend` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Chip reset, asynchronous active low, released synchronously inside |
| soft_rst_n | input | 1 | Soft reset, active low, synchronous to clk |
| dbg_clk_pin | input | 1 | Debug clock pin level, already synchronized |
| dbg_din_pin | input | 1 | Debug serial data-in pin level, already synchronized |
| cause_set | input | N_CAUSE | Interrupt-cause event pulses |
| cause_clr | input | N_CAUSE | Write-one-to-clear of pending causes |
| cause_mask | input | N_CAUSE | Per-cause debug enable mask |
| rfi | input | 1 | Return-from-interrupt pulse |
| freeze | output | 1 | High while the core is held in debug |
| dbg_enabled | output | 1 | Debug mode allowed for this reset epoch |
| mode_valid | output | 1 | Port clock mode has been sampled |
| self_clocked | output | 1 | 1: port clocked by system clock, 0: by debug clock |
| cause_pend | output | N_CAUSE | Sticky pending interrupt causes |

## Verification
Two things can fall in the same cycle: the return-from-interrupt pulse that ends debug, and an entry condition raised by a masked pending cause. The bench provokes this by pulsing `rfi` while the cause that caused the entry is still pending. It expects `freeze` to drop for exactly one cycle and then rise again, because exit has priority and the still-pending cause re-enters. It then clears the cause in the same cycle as a second `rfi` and expects `freeze` to stay low. A set and a clear of the same cause bit in one cycle are judged the same way, by reading `cause_pend` and the entry that follows.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;

  // decisions latched around soft reset negation
  typedef struct packed {
    logic en;     // debug mode allowed
    logic self;   // port clocked by system clock
    logic valid;  // clock mode sampled
  } strap_t;

endpackage

// File: rtl/dbg_rst_sync.sv
module dbg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dbg_strap_sampler.sv
module dbg_strap_sampler
  import dbg_entry_pkg::*;
#(
  parameter int PRE_CYC = 3,
  parameter int IMM_CYC = 7,
  parameter int DIN_CYC = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   soft_rst_n,
  input  logic   dbg_clk_pin,
  input  logic   dbg_din_pin,
  output strap_t strap,
  output logic   imm_req
);
  localparam int CW = $clog2(DIN_CYC + 1);

  logic [PRE_CYC-1:0] hist_q, hist_d;
  logic [PRE_CYC:0]   hist_w;
  logic [CW-1:0]      cnt_q, cnt_d;
  logic               busy_q, busy_d;
  logic               soft_q;
  strap_t             strap_q, strap_d;

  always_comb begin
    hist_w  = {hist_q, dbg_clk_pin};
    hist_d  = hist_w[PRE_CYC-1:0];
    cnt_d   = cnt_q;
    busy_d  = busy_q;
    strap_d = strap_q;
    if (!soft_rst_n) begin
      cnt_d   = '0;
      busy_d  = 1'b0;
      strap_d = '0;
    end else if (!soft_q) begin
      // negation edge: look back PRE_CYC edges
      strap_d.en = hist_q[PRE_CYC-1];
      busy_d     = 1'b1;
      cnt_d      = CW'(1);
    end else if (busy_q) begin
      cnt_d = cnt_q + CW'(1);
      if (cnt_q == CW'(DIN_CYC)) begin
        strap_d.self  = dbg_din_pin;
        strap_d.valid = 1'b1;
        busy_d        = 1'b0;
      end
    end
  end

  assign imm_req = busy_q & soft_rst_n & strap_q.en & dbg_clk_pin &
                   (cnt_q == CW'(IMM_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      soft_q  <= 1'b0;
      strap_q <= '0;
    end else begin
      hist_q  <= hist_d;
      cnt_q   <= cnt_d;
      busy_q  <= busy_d;
      soft_q  <= soft_rst_n;
      strap_q <= strap_d;
    end
  end

  assign strap = strap_q;
endmodule

// File: rtl/dbg_cause_gate.sv
module dbg_cause_gate #(
  parameter int N_CAUSE = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst_n,
  input  logic [N_CAUSE-1:0] cause_set,
  input  logic [N_CAUSE-1:0] cause_clr,
  input  logic [N_CAUSE-1:0] cause_mask,
  output logic [N_CAUSE-1:0] cause_pend,
  output logic               pend_any
);
  logic [N_CAUSE-1:0] cause_q, cause_d;

  always_comb begin
    if (!soft_rst_n) cause_d = '0;
    else             cause_d = (cause_q & ~cause_clr) | cause_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= cause_d;
  end

  assign cause_pend = cause_q;
  assign pend_any   = |(cause_q & cause_mask);
endmodule

// File: rtl/dbg_freeze_ctl.sv
module dbg_freeze_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst_n,
  input  logic enter,
  input  logic rfi,
  output logic freeze
);
  logic frz_q, frz_d;

  always_comb begin
    if (!soft_rst_n) frz_d = 1'b0;
    else if (frz_q)  frz_d = ~rfi;
    else             frz_d = enter;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frz_q <= 1'b0;
    else        frz_q <= frz_d;
  end

  assign freeze = frz_q;
endmodule

// File: rtl/dbg_entry_ctl.sv
module dbg_entry_ctl
  import dbg_entry_pkg::*;
#(
  parameter int N_CAUSE = 8,
  parameter int PRE_CYC = 3,
  parameter int IMM_CYC = 7,
  parameter int DIN_CYC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst_n,
  input  logic               dbg_clk_pin,
  input  logic               dbg_din_pin,
  input  logic [N_CAUSE-1:0] cause_set,
  input  logic [N_CAUSE-1:0] cause_clr,
  input  logic [N_CAUSE-1:0] cause_mask,
  input  logic               rfi,
  output logic               freeze,
  output logic               dbg_enabled,
  output logic               mode_valid,
  output logic               self_clocked,
  output logic [N_CAUSE-1:0] cause_pend
);
  logic   rst_i_n;
  logic   imm_req;
  logic   pend_any;
  logic   enter;
  strap_t strap;

  dbg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  dbg_strap_sampler #(
    .PRE_CYC (PRE_CYC),
    .IMM_CYC (IMM_CYC),
    .DIN_CYC (DIN_CYC)
  ) u_strap (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .soft_rst_n  (soft_rst_n),
    .dbg_clk_pin (dbg_clk_pin),
    .dbg_din_pin (dbg_din_pin),
    .strap       (strap),
    .imm_req     (imm_req)
  );

  dbg_cause_gate #(.N_CAUSE(N_CAUSE)) u_cause (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .soft_rst_n (soft_rst_n),
    .cause_set  (cause_set),
    .cause_clr  (cause_clr),
    .cause_mask (cause_mask),
    .cause_pend (cause_pend),
    .pend_any   (pend_any)
  );

  assign enter = imm_req | (strap.en & strap.valid & pend_any);

  dbg_freeze_ctl u_frz (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .soft_rst_n (soft_rst_n),
    .enter      (enter),
    .rfi        (rfi),
    .freeze     (freeze)
  );

  assign dbg_enabled  = strap.en;
  assign mode_valid   = strap.valid;
  assign self_clocked = strap.self;
endmodule

// File: rtl/dbg_entry_chk.sv
module dbg_entry_chk #(
  parameter int N_CAUSE = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               soft_rst_n,
  input logic               rfi,
  input logic [N_CAUSE-1:0] cause_clr,
  input logic               freeze,
  input logic               dbg_enabled,
  input logic               mode_valid,
  input logic               self_clocked,
  input logic [N_CAUSE-1:0] cause_pend
);
  // R9: exit has priority over any entry condition
  assert_rfi_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && rfi && soft_rst_n) |=> !freeze);

  // R10: soft reset wipes the epoch's decisions
  assert_soft_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst_n |=> (!freeze && !dbg_enabled && !mode_valid && cause_pend == '0));

  // R8: nothing enters debug while it is not allowed
  assert_no_entry_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && !dbg_enabled) |=> !freeze);

  // R6: pending bits only leave through a clear
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_n |=> (($past(cause_pend) & ~$past(cause_clr) & ~cause_pend) == '0));

  // R5: sampled clock mode holds until the next soft reset
  assert_mode_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_valid && soft_rst_n) |=> (mode_valid && $stable(self_clocked)));
endmodule

bind dbg_entry_ctl dbg_entry_chk #(.N_CAUSE(N_CAUSE)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .soft_rst_n   (soft_rst_n),
  .rfi          (rfi),
  .cause_clr    (cause_clr),
  .freeze       (freeze),
  .dbg_enabled  (dbg_enabled),
  .mode_valid   (mode_valid),
  .self_clocked (self_clocked),
  .cause_pend   (cause_pend)
);

// File: tb/dbg_entry_ctl_bench.sv
module dbg_entry_ctl_bench;
  localparam int N = 8;

  logic         clk;
  logic         rst_n;
  logic         soft_rst_n;
  logic         dbg_clk_pin;
  logic         dbg_din_pin;
  logic [N-1:0] cause_set;
  logic [N-1:0] cause_clr;
  logic [N-1:0] cause_mask;
  logic         rfi;
  logic         freeze;
  logic         dbg_enabled;
  logic         mode_valid;
  logic         self_clocked;
  logic [N-1:0] cause_pend;

  int checks   = 0;
  int failures = 0;

  // {pin@E-3, pin@E7, din@E8, exp_en, exp_freeze, exp_self}
  localparam logic [5:0] VEC [5] = '{
    6'b110_110,
    6'b101_101,
    6'b011_001,
    6'b000_000,
    6'b111_111
  };

  dbg_entry_ctl #(.N_CAUSE(N)) u_dbg_entry_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst_n   (soft_rst_n),
    .dbg_clk_pin  (dbg_clk_pin),
    .dbg_din_pin  (dbg_din_pin),
    .cause_set    (cause_set),
    .cause_clr    (cause_clr),
    .cause_mask   (cause_mask),
    .rfi          (rfi),
    .freeze       (freeze),
    .dbg_enabled  (dbg_enabled),
    .mode_valid   (mode_valid),
    .self_clocked (self_clocked),
    .cause_pend   (cause_pend)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // soft reset window; pin high at E-2/E-1 and E1..E6, din inverted before E8
  task automatic window(input logic p3, input logic hold, input logic din,
                        input logic e_en, input logic e_frz, input logic e_self);
    soft_rst_n  = 1'b0;
    dbg_clk_pin = 1'b0;
    dbg_din_pin = ~din;
    step(); step(); step();
    dbg_clk_pin = p3;
    step();                       // E-3
    dbg_clk_pin = 1'b1;
    step(); step();               // E-2, E-1
    chk("R10 freeze cleared in soft reset", freeze, 0);
    soft_rst_n = 1'b1;
    step();                       // E0
    chk("R2 debug enable from pin at E-3", dbg_enabled, e_en);
    for (int k = 1; k <= 6; k++) step();
    chk("R3 no freeze before E7", freeze, 0);
    dbg_clk_pin = hold;
    step();                       // E7
    chk("R3/R4 immediate entry at E7", freeze, e_frz);
    chk("R5 mode not valid before E8", mode_valid, 0);
    dbg_clk_pin = 1'b0;
    dbg_din_pin = din;
    step();                       // E8
    chk("R5 mode valid after E8", mode_valid, 1);
    chk("R5 clock mode from din at E8", self_clocked, e_self);
    dbg_din_pin = ~din;
    step();
    chk("R5 clock mode held", self_clocked, e_self);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n       = 1'b0;
    soft_rst_n  = 1'b0;
    dbg_clk_pin = 1'b0;
    dbg_din_pin = 1'b0;
    cause_set   = '0;
    cause_clr   = '0;
    cause_mask  = '0;
    rfi         = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step(); step(); step();
    chk("R1 freeze after reset", freeze, 0);
    chk("R1 dbg_enabled after reset", dbg_enabled, 0);
    chk("R1 mode_valid after reset", mode_valid, 0);
    chk("R1 cause_pend after reset", cause_pend, 0);

    foreach (VEC[i])
      window(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);

    // causes with debug allowed, no immediate entry
    window(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    cause_mask = 8'h0F;
    cause_set  = 8'h10;
    step();
    cause_set = '0;
    chk("R6 cause latched", cause_pend, 8'h10);
    step();
    chk("R7 masked-off cause no entry", freeze, 0);
    chk("R6 cause sticky", cause_pend, 8'h10);
    cause_clr = 8'h10;
    step();
    cause_clr = '0;
    chk("R6 cause cleared", cause_pend, 0);
    cause_set = 8'h01;
    step();
    cause_set = '0;
    chk("R7 no freeze same cycle as set", freeze, 0);
    step();
    chk("R7 masked cause enters debug", freeze, 1);
    rfi = 1'b1;
    step();
    rfi = 1'b0;
    chk("R9 rfi exits despite pending cause", freeze, 0);
    step();
    chk("R7 pending cause re-enters", freeze, 1);
    rfi       = 1'b1;
    cause_clr = 8'h01;
    step();
    rfi       = 1'b0;
    cause_clr = '0;
    chk("R9 exit with cause cleared", freeze, 0);
    step();
    chk("R9 stays out of debug", freeze, 0);
    rfi = 1'b1;
    step();
    rfi = 1'b0;
    chk("R9 rfi while not frozen no effect", freeze, 0);
    cause_set = 8'h02;
    cause_clr = 8'h02;
    step();
    cause_set = '0;
    cause_clr = '0;
    chk("R6 set wins over clear", cause_pend, 8'h02);
    step();
    chk("R7 entry from bit 1", freeze, 1);
    soft_rst_n = 1'b0;
    step();
    chk("R10 freeze cleared", freeze, 0);
    chk("R10 dbg_enabled cleared", dbg_enabled, 0);
    chk("R10 mode_valid cleared", mode_valid, 0);
    chk("R10 cause_pend cleared", cause_pend, 0);

    // debug not allowed: causes ignored
    window(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    cause_set = 8'h01;
    step();
    cause_set = '0;
    step(); step();
    chk("R8 pending cause while disabled", cause_pend, 8'h01);
    chk("R8 no entry while disabled", freeze, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule